// File: doc/BRIEF.md
# Retired-PC Trace Ring Recorder

This block records where a processor has been. Each time the instruction sequencer reports an instruction boundary, and tracing is active, the block issues one untranslated (physical) single-beat memory write. The write carries the program counter of the instruction about to be dispatched. The target address is a programmable base plus the index held in a 36-bit pointer word.

The pointer word holds two 18-bit halves. The upper half is a negative count of the entries left, and the lower half is the offset into the buffer. Every event advances both halves in one add. When the count half runs out, the pointer wraps: the incremented word has its halves swapped and is then negated. A buffer whose offset starts at zero therefore restarts at its first entry. While its own store is outstanding, the block masks further tracing and holds the sequencer.

Software writes the base and the pointer with a load command, which also enables tracing, and turns tracing off with a stop command. Software reads back the current absolute buffer address, which is the base plus the index.

Top module: `pc_trace_ring`

## Requirements
- R1: After reset, memReq, hold and traceActive are all 0, and no store is issued until a load command arrives.
- R2: A cycle with cfgLoad=1 and cfgStop=0 captures cfgBase and cfgPtr and enables tracing; traceActive is 1 in the following cycle unless a store is outstanding.
- R3: When traceActive=1 and retireValid=1, memReq is 1 from the next cycle. memData equals the retirePc of that cycle. memAddr equals (base + pointer bits 17:0) mod 2^18; pointer bits 35:18 play no part in the address.
- R4: Once raised, memReq stays 1, with memAddr and memData unchanged, until the cycle in which memAck=1. It is 0 from the next cycle. hold equals memReq at all times.
- R5: While a store is outstanding, traceActive is 0 and retireValid is ignored: no second store is issued and the pointer does not change.
- R6: On each accepted event the pointer advances by 2^18+1 modulo 2^36, which increments the count half and the offset half together.
- R7: If pointer bits 35:18 are all ones when an event is accepted, the new pointer is the two's complement of the incremented word with its halves swapped. A pointer loaded as count -N, offset 0 writes base+0 through base+N-1 and then base+0 again.
- R8: ptrView always shows (base + pointer bits 17:0) mod 2^18.
- R9: cfgStop=1 makes traceActive 0 from the next cycle. When cfgStop and cfgLoad are both 1, the stop wins for the enable, while base and pointer are still loaded.
- R10: A retireValid in a cycle with cfgLoad=1 or cfgStop=1 is dropped, and no store follows from it.
- R11: After the acknowledged cycle, traceActive returns to 1 in the next cycle if tracing is still enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | Instruction boundary event from the sequencer |
| retirePc | input | 18 | PC of the instruction about to be dispatched |
| cfgLoad | input | 1 | Load base and pointer, then enable tracing |
| cfgStop | input | 1 | Disable tracing |
| cfgBase | input | 18 | Buffer base for cfgLoad |
| cfgPtr | input | 36 | Pointer word for cfgLoad (count in 35:18, offset in 17:0) |
| ptrView | output | 18 | Readback: base plus current offset |
| traceActive | output | 1 | Tracing enabled and no store outstanding |
| hold | output | 1 | Stall toward the sequencer while a store is outstanding |
| memReq | output | 1 | Physical memory write request |
| memAddr | output | 18 | Physical write address |
| memData | output | 18 | Write data (the traced PC) |
| memAck | input | 1 | Write acknowledge |

## Verification
Two pairs of functions can collide in a single cycle. The first is an acknowledge and a new retire event. The bench holds retireValid high across the acknowledge, and the reference model expects that retire to be masked, with the next store only starting in the cycle after. The second is a configuration command and a retire event. The bench raises cfgLoad, and separately cfgStop, in the same cycle as retireValid, and expects no store to follow while the load still takes effect. Every clock, the bench compares the outputs against a behavioural model of these rules.

// File: rtl/pc_trace_pkg.sv
package pc_trace_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic load;   // capture base and pointer
    logic stop;   // disable command seen
    logic fire;   // accept a trace event this cycle
    logic done;   // outstanding store acknowledged
  } traceStrobes_t;
endpackage

// File: rtl/pc_trace_ctl.sv
module pc_trace_ctl
  import pc_trace_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          retireValid,
  input  logic          cfgLoad,
  input  logic          cfgStop,
  input  logic          memAck,
  output traceStrobes_t strobes,
  output logic          busy,
  output logic          traceActive
);
  logic enQ;
  logic busyQ;

  // configuration commands take the cycle; an event needs an idle, enabled recorder
  always_comb begin
    strobes.load = cfgLoad;
    strobes.stop = cfgStop;
    strobes.fire = enQ & ~busyQ & retireValid & ~cfgLoad & ~cfgStop;
    strobes.done = busyQ & memAck;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      busyQ <= 1'b0;
    end else begin
      if (cfgStop)      enQ <= 1'b0;
      else if (cfgLoad) enQ <= 1'b1;
      if (strobes.fire)      busyQ <= 1'b1;
      else if (strobes.done) busyQ <= 1'b0;
    end
  end

  assign busy        = busyQ;
  assign traceActive = enQ & ~busyQ;

  AST_REQ_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rstN)
    busy && !memAck |=> busy); // R4
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    cfgStop |=> !traceActive); // R9
  AST_LOAD_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    cfgLoad && !cfgStop && !busy |=> traceActive); // R2
endmodule

// File: rtl/pc_trace_dp.sv
module pc_trace_dp
  import pc_trace_pkg::*;
#(
  parameter int HALF_W = 18,
  parameter int PC_W   = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  traceStrobes_t       strobes,
  input  logic [HALF_W-1:0]   cfgBase,
  input  logic [2*HALF_W-1:0] cfgPtr,
  input  logic [PC_W-1:0]     retirePc,
  output logic [HALF_W-1:0]   memAddr,
  output logic [PC_W-1:0]     memData,
  output logic [HALF_W-1:0]   ptrView
);
  localparam int PTR_W = 2 * HALF_W;
  localparam logic [PTR_W-1:0] STEP = (PTR_W'(1) << HALF_W) | PTR_W'(1);

  logic [HALF_W-1:0] baseQ;
  logic [PTR_W-1:0]  ptrQ;
  logic [HALF_W-1:0] addrQ;
  logic [PC_W-1:0]   dataQ;

  logic [PTR_W-1:0]  incPtr;
  logic [PTR_W-1:0]  swapped;
  logic [PTR_W-1:0]  nextPtr;
  logic              atEnd;
  logic [HALF_W-1:0] absAddr;

  always_comb begin
    incPtr  = ptrQ + STEP;
    atEnd   = &ptrQ[PTR_W-1:HALF_W];
    swapped = {incPtr[HALF_W-1:0], incPtr[PTR_W-1:HALF_W]};
    nextPtr = atEnd ? (~swapped + PTR_W'(1)) : incPtr;
    absAddr = baseQ + ptrQ[HALF_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      ptrQ  <= '0;
      addrQ <= '0;
      dataQ <= '0;
    end else if (strobes.load) begin
      baseQ <= cfgBase;
      ptrQ  <= cfgPtr;
    end else if (strobes.fire) begin
      addrQ <= absAddr;
      dataQ <= retirePc;
      ptrQ  <= nextPtr;
    end
  end

  assign memAddr = addrQ;
  assign memData = dataQ;
  assign ptrView = absAddr;

  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire && (&ptrQ[PTR_W-1:HALF_W]) |=> ptrQ[HALF_W-1:0] == '0); // R7
endmodule

// File: rtl/pc_trace_ring.sv
module pc_trace_ring
  import pc_trace_pkg::*;
#(
  parameter int HALF_W = 18,
  parameter int PC_W   = 18
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                retireValid,
  input  logic [PC_W-1:0]     retirePc,
  input  logic                cfgLoad,
  input  logic                cfgStop,
  input  logic [HALF_W-1:0]   cfgBase,
  input  logic [2*HALF_W-1:0] cfgPtr,
  output logic [HALF_W-1:0]   ptrView,
  output logic                traceActive,
  output logic                hold,
  output logic                memReq,
  output logic [HALF_W-1:0]   memAddr,
  output logic [PC_W-1:0]     memData,
  input  logic                memAck
);
  traceStrobes_t strobes;
  logic          busy;

  pc_trace_ctl ctl (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .cfgLoad(cfgLoad),
    .cfgStop(cfgStop), .memAck(memAck), .strobes(strobes), .busy(busy),
    .traceActive(traceActive)
  );

  pc_trace_dp #(.HALF_W(HALF_W), .PC_W(PC_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cfgBase(cfgBase),
    .cfgPtr(cfgPtr), .retirePc(retirePc), .memAddr(memAddr),
    .memData(memData), .ptrView(ptrView)
  );

  assign memReq = busy;
  assign hold   = busy;

  AST_PAYLOAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> $stable(memAddr) && $stable(memData)); // R4
endmodule

// File: tb/pc_trace_ring_test.sv
`timescale 1ns/1ps
module pc_trace_ring_test;
  localparam longint M18 = 64'h3FFFF;
  localparam longint M36 = 64'hF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retireValid = 1'b0;
  logic [17:0] retirePc = '0;
  logic        cfgLoad = 1'b0;
  logic        cfgStop = 1'b0;
  logic [17:0] cfgBase = '0;
  logic [35:0] cfgPtr = '0;
  logic [17:0] ptrView;
  logic        traceActive;
  logic        hold;
  logic        memReq;
  logic [17:0] memAddr;
  logic [17:0] memData;
  logic        memAck = 1'b0;

  int total = 0;
  int bad = 0;

  pc_trace_ring uut (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .retirePc(retirePc),
    .cfgLoad(cfgLoad), .cfgStop(cfgStop), .cfgBase(cfgBase), .cfgPtr(cfgPtr),
    .ptrView(ptrView), .traceActive(traceActive), .hold(hold),
    .memReq(memReq), .memAddr(memAddr), .memData(memData), .memAck(memAck)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  bit     mEn, mBusy;
  longint mBase, mPtr, mAddr, mData;

  always @(posedge clk) begin
    bit fire;
    longint nxt, sw;
    if (!rstN) begin
      mEn = 0; mBusy = 0; mBase = 0; mPtr = 0; mAddr = 0; mData = 0;
    end else begin
      fire = mEn && !mBusy && retireValid && !cfgLoad && !cfgStop;
      if (cfgLoad) begin
        mBase = longint'(cfgBase);
        mPtr  = longint'(cfgPtr);
      end
      if (fire) begin
        mAddr = (mBase + (mPtr & M18)) & M18;
        mData = longint'(retirePc);
        nxt = (mPtr + (64'd1 << 18) + 1) & M36;
        if (((mPtr >> 18) & M18) == M18) begin
          sw  = ((nxt & M18) << 18) | ((nxt >> 18) & M18);
          nxt = (M36 + 1 - sw) & M36;
        end
        mPtr = nxt;
        mBusy = 1;
      end else if (mBusy && memAck) begin
        mBusy = 0;
      end
      if (cfgStop) mEn = 0;
      else if (cfgLoad) mEn = 1;
    end
  end

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R4 memReq", longint'(memReq), longint'(mBusy));
      chk("R4 hold", longint'(hold), longint'(mBusy));
      chk("R5 traceActive", longint'(traceActive), longint'(mEn && !mBusy));
      chk("R8 ptrView", longint'(ptrView), (mBase + (mPtr & M18)) & M18);
      if (mBusy) begin
        chk("R3 memAddr", longint'(memAddr), mAddr);
        chk("R3 memData", longint'(memData), mData);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic loadCfg(longint base, longint ptr);
    cfgBase = 18'(base); cfgPtr = 36'(ptr); cfgLoad = 1'b1;
    cyc();
    cfgLoad = 1'b0;
  endtask

  function automatic longint mkPtr(int count, longint off);
    return (((M18 + 1 - longint'(count)) & M18) << 18) | (off & M18);
  endfunction

  task automatic tracePc(longint pc, longint expAddr, int waitCyc, string req);
    retireValid = 1'b1; retirePc = 18'(pc);
    cyc();
    retireValid = 1'b0;
    chk(req, longint'(memAddr), expAddr);
    chk("R3 data", longint'(memData), pc);
    repeat (waitCyc) cyc();
    memAck = 1'b1;
    cyc();
    memAck = 1'b0;
    chk("R11 active again", longint'(traceActive), 1);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    // R1: reset state
    chk("R1 memReq", longint'(memReq), 0);
    chk("R1 hold", longint'(hold), 0);
    chk("R1 traceActive", longint'(traceActive), 0);
    rstN = 1'b1;
    retireValid = 1'b1; retirePc = 18'h123;
    cyc(); cyc();
    retireValid = 1'b0;
    chk("R1 no store before load", longint'(memReq), 0);

    // R2 / R7: 4-entry ring at 0x100
    loadCfg(64'h100, mkPtr(4, 0));
    chk("R2 enabled", longint'(traceActive), 1);
    chk("R8 readback", longint'(ptrView), 64'h100);
    for (int i = 0; i < 6; i++)
      tracePc(64'h2000 + i, 64'h100 + (i % 4), i % 3, "R7 ring address");
    chk("R6 after wrap", longint'(ptrView), 64'h102);

    // R6 / R3: nonzero offset, count half not in the address
    loadCfg(64'h200, mkPtr(10, 5));
    tracePc(64'h3AB, 64'h205, 1, "R3 offset address");
    chk("R6 advance", longint'(ptrView), 64'h206);

    // R3: base + offset wraps modulo 2^18
    loadCfg(64'h3FFFE, mkPtr(8, 3));
    tracePc(64'h1, 64'h1, 0, "R3 address modulo");

    // R5: retire held high across an outstanding store and its ack
    loadCfg(64'h400, mkPtr(16, 0));
    retireValid = 1'b1; retirePc = 18'h55;
    cyc();
    retirePc = 18'h66;
    repeat (3) cyc();
    chk("R5 payload held", longint'(memData), 64'h55);
    chk("R5 still one request", longint'(memAddr), 64'h400);
    memAck = 1'b1;
    cyc();
    memAck = 1'b0;
    chk("R5 masked in ack cycle", longint'(memReq), 0);
    cyc();
    retireValid = 1'b0;
    chk("R5 next store", longint'(memAddr), 64'h401);
    memAck = 1'b1; cyc(); memAck = 1'b0;

    // R10: stop with retire in the same cycle
    retireValid = 1'b1; cfgStop = 1'b1;
    cyc();
    cfgStop = 1'b0; retireValid = 1'b0;
    chk("R10 stop drops event", longint'(memReq), 0);
    chk("R9 stopped", longint'(traceActive), 0);
    retireValid = 1'b1;
    cyc();
    retireValid = 1'b0;
    chk("R9 no store when stopped", longint'(memReq), 0);

    // R10: load with retire in the same cycle
    retireValid = 1'b1; cfgBase = 18'h500; cfgPtr = 36'(mkPtr(4, 1)); cfgLoad = 1'b1;
    cyc();
    cfgLoad = 1'b0; retireValid = 1'b0;
    chk("R10 load drops event", longint'(memReq), 0);
    chk("R2 load took effect", longint'(ptrView), 64'h501);

    // R9: stop wins over load, pointer still loaded
    cfgBase = 18'h600; cfgPtr = 36'(mkPtr(4, 2)); cfgLoad = 1'b1; cfgStop = 1'b1;
    cyc();
    cfgLoad = 1'b0; cfgStop = 1'b0;
    chk("R9 stop beats load", longint'(traceActive), 0);
    chk("R9 values loaded", longint'(ptrView), 64'h602);

    repeat (2) cyc();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule